// File: doc/BRIEF.md
# SDRAM Command Decoder

This block sits on the controller-facing edge of a DDR4-style memory device model. On every rising clock edge it samples the chip select, the activate strobe, the three multi-purpose command pins, the bank group, the bank address and the address bus. It sorts what it sees into one of eight command kinds and presents a registered decoded-command record in the next cycle.

Several pins change meaning with the command. When the activate strobe is low, the three command pins become row address bits 16, 15 and 14. When it is high, they select among the other commands. Address bit 10 is an auto-precharge request on a read or a write, and it chooses all banks or one bank on a precharge. Address bit 12, taken low, chops the burst on a read or a write.

A device-width parameter adapts the decoder to the configuration. The x16 width has only one bank-group pin, so the upper bank-group bit is forced to zero. Address bit 17 is kept only in the x4 width. Later stages of the device model use the record without looking at the raw pins again.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: While rstN is low at a rising edge, all outputs are cleared after that edge: cmdValid=0, cmdErr=0, cmdType=0 and every field is 0.
- R2: When csN is high at an edge, the next cycle shows cmdValid=0, cmdErr=0, cmdType=0 (no-op) and all fields 0, whatever the other pins are.
- R3: csN=0 with actN=0 decodes as activate (cmdType=1). cmdBg and cmdBa take the bank inputs. cmdAddr = {A17, rasN, casN, weN, addr[13:0]}, where the pins rasN, casN and weN serve as row bits 16, 15 and 14.
- R4: csN=0, actN=1 and {rasN,casN,weN}=101 decodes as read (cmdType=2); 100 decodes as write (cmdType=3). cmdBg and cmdBa take the bank inputs. cmdAddr = {8'b0, addr[9:0]}.
- R5: cmdAutoPre equals addr[10] for a read or a write, and it is 0 for every other command.
- R6: cmdBurstChop is 1 when addr[12] is 0 on a read or a write, and it is 0 otherwise.
- R7: {rasN,casN,weN}=010 with actN=1 is a precharge. With addr[10]=0 it is single-bank (cmdType=4) with cmdBg and cmdBa set. With addr[10]=1 it is all-bank (cmdType=5) with cmdBg=0 and cmdBa=0. In both cases cmdAddr=0.
- R8: {rasN,casN,weN}=000 with actN=1 is a mode register set (cmdType=6). cmdMrIdx = {bg[0], ba[1:0]}. cmdAddr = {A17, 3'b000, addr[13:0]}. cmdBg and cmdBa are 0. cmdMrIdx is 0 for all other commands.
- R9: {rasN,casN,weN}=001 with actN=1 is a refresh (cmdType=7) with all fields 0.
- R10: {rasN,casN,weN}=111 with actN=1 is a no-op: cmdValid=0 and cmdErr=0. The reserved codes 011 and 110 give cmdType=0 and cmdValid=0, with cmdErr=1 for exactly that one cycle.
- R11: With DEV_WIDTH=16, cmdBg[1] is always 0. A17 (input a17) appears in cmdAddr bit 17 only when DEV_WIDTH=4, and that bit is 0 for other widths.
- R12: The record for the inputs sampled at edge k appears after edge k and lasts one cycle. Back-to-back commands each give their own one-cycle cmdValid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| actN | input | 1 | Activate strobe, active low |
| rasN | input | 1 | Command pin / row bit 16 |
| casN | input | 1 | Command pin / row bit 15 |
| weN | input | 1 | Command pin / row bit 14 |
| bg | input | 2 | Bank group |
| ba | input | 2 | Bank address |
| addr | input | 14 | Address bits 13..0 |
| a17 | input | 1 | Address bit 17 |
| cmdValid | output | 1 | One-cycle strobe per accepted command |
| cmdErr | output | 1 | Reserved command code seen |
| cmdType | output | 3 | 0 nop, 1 act, 2 read, 3 write, 4 pre, 5 pre-all, 6 mode set, 7 refresh |
| cmdBg | output | 2 | Target bank group |
| cmdBa | output | 2 | Target bank |
| cmdAddr | output | 18 | Row, column or mode opcode |
| cmdAutoPre | output | 1 | Auto-precharge request |
| cmdBurstChop | output | 1 | Burst chop request |
| cmdMrIdx | output | 3 | Mode register index |

## Verification
The hardest cases to reach are the width-dependent masks. A single instance can never show bank-group bit 1 forced to zero and address bit 17 passed through at the same time. The bench therefore drives three instances, at widths 8, 16 and 4, from the same pins and checks each against its own expected record. Random stimulus alone seldom combines a reserved command code with a precharge-all directly after it, or makes a back-to-back read and write differ only in the low pin. Directed sequences cover these cases before and after the seeded random phase.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_MRS  = 3'd6,
    CMD_REF  = 3'd7
  } cmd_e;

  // strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic isAct;
    logic isRd;
    logic isWr;
    logic isPre;
    logic isPreAll;
    logic isMrs;
    logic isRef;
    logic isRsv;
  } strobes_t;

endpackage

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     csN,
  input  logic     actN,
  input  logic     rasN,
  input  logic     casN,
  input  logic     weN,
  input  logic     a10,
  output strobes_t strb,
  output logic     cmdValid,
  output logic     cmdErr,
  output cmd_e     cmdType
);

  cmd_e typeNext;

  always_comb begin
    strb = '0;
    if (!csN) begin
      if (!actN) begin
        strb.isAct = 1'b1;
      end else begin
        case ({rasN, casN, weN})
          3'b000:  strb.isMrs = 1'b1;
          3'b001:  strb.isRef = 1'b1;
          3'b010: begin
            if (a10) strb.isPreAll = 1'b1;
            else     strb.isPre    = 1'b1;
          end
          3'b100:  strb.isWr = 1'b1;
          3'b101:  strb.isRd = 1'b1;
          3'b111:  ;
          default: strb.isRsv = 1'b1;
        endcase
      end
    end
  end

  always_comb begin
    typeNext = CMD_NOP;
    if (strb.isAct)    typeNext = CMD_ACT;
    if (strb.isRd)     typeNext = CMD_RD;
    if (strb.isWr)     typeNext = CMD_WR;
    if (strb.isPre)    typeNext = CMD_PRE;
    if (strb.isPreAll) typeNext = CMD_PREA;
    if (strb.isMrs)    typeNext = CMD_MRS;
    if (strb.isRef)    typeNext = CMD_REF;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdErr   <= 1'b0;
      cmdType  <= CMD_NOP;
    end else begin
      cmdValid <= (typeNext != CMD_NOP);
      cmdErr   <= strb.isRsv;
      cmdType  <= typeNext;
    end
  end

  assert_valid_needs_cs_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $past(!csN));

  assert_err_alone_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdErr |-> (!cmdValid && cmdType == CMD_NOP));

  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  assert_act_from_pin_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdType == CMD_ACT) |-> $past(!actN));

endmodule

// File: rtl/sdram_cmd_dp.sv
module sdram_cmd_dp
  import sdram_cmd_pkg::*;
#(
  parameter int DEV_WIDTH = 8,
  parameter int BG_W      = 2,
  parameter int BA_W      = 2,
  parameter int LOW_W     = 14,
  parameter int COL_W     = 10,
  localparam int ROW_W    = LOW_W + 4,
  localparam int MR_W     = BA_W + 1
)(
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strb,
  input  logic             rasN,
  input  logic             casN,
  input  logic             weN,
  input  logic [BG_W-1:0]  bg,
  input  logic [BA_W-1:0]  ba,
  input  logic [LOW_W-1:0] addr,
  input  logic             a17,
  output logic [BG_W-1:0]  cmdBg,
  output logic [BA_W-1:0]  cmdBa,
  output logic [ROW_W-1:0] cmdAddr,
  output logic             cmdAutoPre,
  output logic             cmdBurstChop,
  output logic [MR_W-1:0]  cmdMrIdx
);

  logic [BG_W-1:0]  bgEff;
  logic             a17Eff;
  logic [BG_W-1:0]  bgNext;
  logic [BA_W-1:0]  baNext;
  logic [ROW_W-1:0] addrNext;
  logic             apNext;
  logic             bcNext;
  logic [MR_W-1:0]  mrNext;

  generate
    if (DEV_WIDTH == 16) begin : gBgNarrow
      if (BG_W > 1) begin : gPad
        assign bgEff = {{(BG_W-1){1'b0}}, bg[0]};
      end else begin : gOne
        assign bgEff = bg;
      end
    end else begin : gBgFull
      assign bgEff = bg;
    end

    if (DEV_WIDTH == 4) begin : gA17On
      assign a17Eff = a17;
    end else begin : gA17Off
      assign a17Eff = 1'b0;
    end
  endgenerate

  always_comb begin
    bgNext   = '0;
    baNext   = '0;
    addrNext = '0;
    apNext   = 1'b0;
    bcNext   = 1'b0;
    mrNext   = '0;
    if (strb.isAct) begin
      bgNext   = bgEff;
      baNext   = ba;
      addrNext = {a17Eff, rasN, casN, weN, addr};
    end
    if (strb.isRd || strb.isWr) begin
      bgNext   = bgEff;
      baNext   = ba;
      addrNext = {{(ROW_W-COL_W){1'b0}}, addr[COL_W-1:0]};
      apNext   = addr[10];
      bcNext   = ~addr[12];
    end
    if (strb.isPre) begin
      bgNext = bgEff;
      baNext = ba;
    end
    if (strb.isMrs) begin
      mrNext   = {bg[0], ba};
      addrNext = {a17Eff, 3'b000, addr};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdBg        <= '0;
      cmdBa        <= '0;
      cmdAddr      <= '0;
      cmdAutoPre   <= 1'b0;
      cmdBurstChop <= 1'b0;
      cmdMrIdx     <= '0;
    end else begin
      cmdBg        <= bgNext;
      cmdBa        <= baNext;
      cmdAddr      <= addrNext;
      cmdAutoPre   <= apNext;
      cmdBurstChop <= bcNext;
      cmdMrIdx     <= mrNext;
    end
  end

  assert_ap_only_rdwr_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmdAutoPre |-> $past(strb.isRd || strb.isWr));

  assert_bc_only_rdwr_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmdBurstChop |-> $past(strb.isRd || strb.isWr));

  assert_mr_only_mrs_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdMrIdx != '0) |-> $past(strb.isMrs));

  assert_prea_no_bank_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.isPreAll) |-> (cmdBg == '0 && cmdBa == '0));

  generate
    if (DEV_WIDTH == 16 && BG_W > 1) begin : gChkBg
      assert_bg1_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
        cmdBg[BG_W-1] == 1'b0);
    end
    if (DEV_WIDTH != 4) begin : gChkA17
      assert_a17_masked_R11: assert property (@(posedge clk) disable iff (!rstN)
        cmdAddr[ROW_W-1] == 1'b0);
    end
  endgenerate

endmodule

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder
  import sdram_cmd_pkg::*;
#(
  parameter int DEV_WIDTH = 8,
  parameter int BG_W      = 2,
  parameter int BA_W      = 2,
  parameter int LOW_W     = 14,
  parameter int COL_W     = 10,
  localparam int ROW_W    = LOW_W + 4
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             actN,
  input  logic             rasN,
  input  logic             casN,
  input  logic             weN,
  input  logic [BG_W-1:0]  bg,
  input  logic [BA_W-1:0]  ba,
  input  logic [LOW_W-1:0] addr,
  input  logic             a17,
  output logic             cmdValid,
  output logic             cmdErr,
  output logic [2:0]       cmdType,
  output logic [BG_W-1:0]  cmdBg,
  output logic [BA_W-1:0]  cmdBa,
  output logic [ROW_W-1:0] cmdAddr,
  output logic             cmdAutoPre,
  output logic             cmdBurstChop,
  output logic [BA_W:0]    cmdMrIdx
);

  strobes_t strb;
  cmd_e     typeQ;

  sdram_cmd_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .actN     (actN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .a10      (addr[10]),
    .strb     (strb),
    .cmdValid (cmdValid),
    .cmdErr   (cmdErr),
    .cmdType  (typeQ)
  );

  assign cmdType = typeQ;

  sdram_cmd_dp #(
    .DEV_WIDTH (DEV_WIDTH),
    .BG_W      (BG_W),
    .BA_W      (BA_W),
    .LOW_W     (LOW_W),
    .COL_W     (COL_W)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .rasN         (rasN),
    .casN         (casN),
    .weN          (weN),
    .bg           (bg),
    .ba           (ba),
    .addr         (addr),
    .a17          (a17),
    .cmdBg        (cmdBg),
    .cmdBa        (cmdBa),
    .cmdAddr      (cmdAddr),
    .cmdAutoPre   (cmdAutoPre),
    .cmdBurstChop (cmdBurstChop),
    .cmdMrIdx     (cmdMrIdx)
  );

endmodule

// File: tb/tb_sdram_cmd_decoder.sv
module tb_sdram_cmd_decoder;

  typedef struct packed {
    logic        cs;
    logic        act;
    logic        ras;
    logic        cas;
    logic        we;
    logic [1:0]  bg;
    logic [1:0]  ba;
    logic [13:0] addr;
    logic        a17;
  } vec_t;

  typedef struct packed {
    logic        valid;
    logic        err;
    logic [2:0]  kind;
    logic [1:0]  bg;
    logic [1:0]  ba;
    logic [17:0] addr;
    logic        ap;
    logic        bc;
    logic [2:0]  mr;
  } rec_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  vec_t v = '0;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  rec_t got8, got16, got4;

  sdram_cmd_decoder dut (
    .clk(clk), .rstN(rstN), .csN(v.cs), .actN(v.act), .rasN(v.ras),
    .casN(v.cas), .weN(v.we), .bg(v.bg), .ba(v.ba), .addr(v.addr), .a17(v.a17),
    .cmdValid(got8.valid), .cmdErr(got8.err), .cmdType(got8.kind),
    .cmdBg(got8.bg), .cmdBa(got8.ba), .cmdAddr(got8.addr),
    .cmdAutoPre(got8.ap), .cmdBurstChop(got8.bc), .cmdMrIdx(got8.mr));

  sdram_cmd_decoder #(.DEV_WIDTH(16)) dut16 (
    .clk(clk), .rstN(rstN), .csN(v.cs), .actN(v.act), .rasN(v.ras),
    .casN(v.cas), .weN(v.we), .bg(v.bg), .ba(v.ba), .addr(v.addr), .a17(v.a17),
    .cmdValid(got16.valid), .cmdErr(got16.err), .cmdType(got16.kind),
    .cmdBg(got16.bg), .cmdBa(got16.ba), .cmdAddr(got16.addr),
    .cmdAutoPre(got16.ap), .cmdBurstChop(got16.bc), .cmdMrIdx(got16.mr));

  sdram_cmd_decoder #(.DEV_WIDTH(4)) dut4 (
    .clk(clk), .rstN(rstN), .csN(v.cs), .actN(v.act), .rasN(v.ras),
    .casN(v.cas), .weN(v.we), .bg(v.bg), .ba(v.ba), .addr(v.addr), .a17(v.a17),
    .cmdValid(got4.valid), .cmdErr(got4.err), .cmdType(got4.kind),
    .cmdBg(got4.bg), .cmdBa(got4.ba), .cmdAddr(got4.addr),
    .cmdAutoPre(got4.ap), .cmdBurstChop(got4.bc), .cmdMrIdx(got4.mr));

  // expected record from the requirements
  function automatic rec_t expect_rec(int w, vec_t x);
    rec_t e;
    logic [1:0] bgm;
    logic a17m;
    e = '0;
    bgm = (w == 16) ? {1'b0, x.bg[0]} : x.bg;
    a17m = (w == 4) ? x.a17 : 1'b0;
    if (x.cs) return e;                                   // R2
    if (!x.act) begin                                     // R3
      e.valid = 1'b1; e.kind = 3'd1; e.bg = bgm; e.ba = x.ba;
      e.addr = {a17m, x.ras, x.cas, x.we, x.addr};
      return e;
    end
    case ({x.ras, x.cas, x.we})
      3'b000: begin                                       // R8
        e.valid = 1'b1; e.kind = 3'd6; e.mr = {x.bg[0], x.ba};
        e.addr = {a17m, 3'b000, x.addr};
      end
      3'b001: begin e.valid = 1'b1; e.kind = 3'd7; end    // R9
      3'b010: begin                                       // R7
        e.valid = 1'b1;
        if (x.addr[10]) e.kind = 3'd5;
        else begin e.kind = 3'd4; e.bg = bgm; e.ba = x.ba; end
      end
      3'b100, 3'b101: begin                               // R4 R5 R6
        e.valid = 1'b1; e.kind = x.we ? 3'd2 : 3'd3;
        e.bg = bgm; e.ba = x.ba; e.addr = {8'b0, x.addr[9:0]};
        e.ap = x.addr[10]; e.bc = ~x.addr[12];
      end
      3'b111: ;                                           // R10
      default: e.err = 1'b1;                              // R10
    endcase
    return e;
  endfunction

  function automatic string tag_of(vec_t x);
    if (x.cs) return "R2";
    if (!x.act) return "R3";
    case ({x.ras, x.cas, x.we})
      3'b000: return "R8";
      3'b001: return "R9";
      3'b010: return "R7";
      3'b100, 3'b101: return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic check_rec(string tag, rec_t act_r, rec_t exp_r);
    checks++;
    if (act_r !== exp_r) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act_r, exp_r);
    end
  endtask

  task automatic check_bit(string tag, logic a, logic e);
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, a, e);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic do_cmd(vec_t x, string over);
    rec_t e8, e16, e4;
    string t;
    v = x;
    @(posedge clk);
    @(negedge clk);
    e8 = expect_rec(8, x);
    e16 = expect_rec(16, x);
    e4 = expect_rec(4, x);
    t = (over != "") ? over : tag_of(x);
    check_rec(t, got8, e8);
    check_rec("R11", got16, e16);
    check_rec("R11", got4, e4);
    if (!x.cs && x.act && x.ras && !x.cas) begin
      check_bit("R5", got8.ap, x.addr[10]);
      check_bit("R6", got8.bc, ~x.addr[12]);
    end
  endtask

  function automatic vec_t mk(logic cs, logic act, logic [2:0] c, logic [1:0] bg,
                              logic [1:0] ba, logic [13:0] a, logic a17);
    vec_t x;
    x.cs = cs; x.act = act; {x.ras, x.cas, x.we} = c;
    x.bg = bg; x.ba = ba; x.addr = a; x.a17 = a17;
    return x;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    vec_t x;
    void'($urandom(32'd20240611));
    // R1: reset with a read held on the pins
    v = mk(1'b0, 1'b1, 3'b101, 2'b11, 2'b11, 14'h3fff, 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_rec("R1", got8, '0);
    check_rec("R1", got16, '0);
    check_rec("R1", got4, '0);
    rstN = 1'b1;

    // directed corners
    do_cmd(mk(1'b1, 1'b0, 3'b000, 2'b11, 2'b11, 14'h3fff, 1'b1), "R2");
    do_cmd(mk(1'b0, 1'b0, 3'b101, 2'b10, 2'b01, 14'h2aaa, 1'b1), "R3");
    do_cmd(mk(1'b0, 1'b0, 3'b010, 2'b11, 2'b10, 14'h0001, 1'b1), "R11");
    do_cmd(mk(1'b0, 1'b1, 3'b101, 2'b01, 2'b11, 14'h0400, 1'b0), "R5");
    do_cmd(mk(1'b0, 1'b1, 3'b100, 2'b01, 2'b11, 14'h1000, 1'b0), "R6");
    do_cmd(mk(1'b0, 1'b1, 3'b100, 2'b10, 2'b00, 14'h03ff, 1'b0), "R12");
    do_cmd(mk(1'b0, 1'b1, 3'b101, 2'b10, 2'b00, 14'h03ff, 1'b0), "R12");
    do_cmd(mk(1'b1, 1'b1, 3'b101, 2'b10, 2'b00, 14'h03ff, 1'b0), "R12");
    do_cmd(mk(1'b0, 1'b1, 3'b011, 2'b11, 2'b11, 14'h0400, 1'b1), "R10");
    do_cmd(mk(1'b0, 1'b1, 3'b010, 2'b11, 2'b11, 14'h0400, 1'b1), "R7");
    do_cmd(mk(1'b0, 1'b1, 3'b010, 2'b11, 2'b01, 14'h0000, 1'b1), "R7");
    do_cmd(mk(1'b0, 1'b1, 3'b110, 2'b00, 2'b00, 14'h0000, 1'b0), "R10");
    do_cmd(mk(1'b0, 1'b1, 3'b111, 2'b11, 2'b11, 14'h3fff, 1'b1), "R10");
    do_cmd(mk(1'b0, 1'b1, 3'b000, 2'b11, 2'b10, 14'h1234, 1'b1), "R8");
    do_cmd(mk(1'b0, 1'b1, 3'b000, 2'b10, 2'b00, 14'h0042, 1'b0), "R8");
    do_cmd(mk(1'b0, 1'b1, 3'b001, 2'b11, 2'b11, 14'h3fff, 1'b1), "R9");

    // seeded random phase
    for (int i = 0; i < 600; i++) begin
      x = vec_t'({$urandom, $urandom});
      x.cs = ($urandom_range(0, 6) == 0);
      x.act = ($urandom_range(0, 3) != 0);
      do_cmd(x, "");
    end

    // R1 again: reset mid-stream clears the record
    v = mk(1'b0, 1'b0, 3'b111, 2'b11, 2'b11, 14'h3fff, 1'b1);
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check_rec("R1", got8, '0);
    rstN = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule